// File: doc/BRIEF.md
# Translation Cache with Hardware Table Walker

This block translates virtual addresses to physical addresses through a small, fully associative cache of translations. A requester presents a virtual address with a load or store flag under a valid/ready handshake. When the virtual page is cached, the physical address is returned in the same cycle. Pages are 4 KiB, so the 12 low address bits pass through unchanged.

When the page is not cached, the block keeps the requester waiting and runs a table walk of its own. It reads one 32-bit entry from a single-level page table in memory. The table starts at the base address input and is indexed by virtual page number. If the entry is present, the block installs it and then retries the request, which then completes as a hit. If the entry is not present, the block answers with a fault and changes nothing.

Each cached entry carries a referenced flag and a modified flag. When a modified entry is evicted, the block writes it back to its page-table word before the new entry takes its slot. A clear input erases all referenced flags, and a flush input drops every cached translation.

Top module: `tlb_walker_top`

## Requirements
- R1: A request whose page is cached is accepted in the same cycle (reqReady high while reqValid is high), with respPaddr = {cached physical page, reqVaddr[11:0]} and respFault low, and with no memory access.
- R2: There are 16 entries with fully associative placement, and at most one valid entry matches any virtual page.
- R3: A request for an uncached page holds reqReady low and issues a memory read at ptBase + 4 × VPN, where VPN = vaddr[31:12]. A table word has present in bit 0, referenced in bit 1, modified in bit 2 and the physical page number in bits 31:12.
- R4: When the table word read is present, the entry is installed with both flags clear, and the held request then completes as a hit carrying that physical page.
- R5: When the table word read is not present, the request is accepted with respFault high. No entry is installed, no memory write occurs, and a repeat of the request walks the table again.
- R6: Every accepted hit sets the entry's referenced flag, and every accepted store hit also sets its modified flag. The modified flag stays set until the entry is evicted.
- R7: A clearRef pulse clears the referenced flag of every entry in one cycle.
- R8: The slot that receives a new entry is the lowest-numbered empty slot. When all slots are full, it is the slot at a rotating pointer. The pointer starts at 0 after reset and advances by one, wrapping, after each install into a full array.
- R9: If the chosen slot holds a valid modified entry, the walker first writes the word {its physical page, 9'b0, modified=1, its referenced flag, present=1} to ptBase + 4 × its VPN. The write happens after the read and before the install. A clean slot causes no write.
- R10: An invalAll pulse makes every entry invalid, without any write-back, so the next request for any page walks the table.
- R11: memValid stays high, with memAddr unchanged, until memDone is returned. memValid is low while the walker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqVaddr | input | 32 | Virtual address |
| reqWrite | input | 1 | Request is a store |
| reqReady | output | 1 | Request accepted this cycle |
| respPaddr | output | 32 | Physical address, valid on acceptance without fault |
| respFault | output | 1 | Accepted request faulted (page not present) |
| ptBase | input | 32 | Page-table base byte address |
| clearRef | input | 1 | Clear all referenced flags |
| invalAll | input | 1 | Invalidate all entries |
| memValid | output | 1 | Memory request pending |
| memWe | output | 1 | Pending request is a write |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Write data |
| memDone | input | 1 | Memory request completed (read data valid) |
| memRdata | input | 32 | Read data |

## Verification
A hit is combinational: reqReady and respPaddr are due in the same cycle as reqValid, so the bench drives each request just after a falling edge and samples 1 ns later. On a miss, memValid rises in the first cycle after the request is seen. The bench memory answers on the third falling edge that finds memValid high, and the install cycle follows that. The bench therefore does not predict a fixed latency. It samples after every falling edge until reqReady rises, and counts the wait cycles so that hits (zero waits) can be told apart from walks. Write-back content and order are checked in the memory model at the falling edge where memDone is raised, and the same model checks that the address held steady while the request was pending.

// File: rtl/tlbPkg.sv
package tlbPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WBACK,
    ST_FILL,
    ST_FAULT
  } walkState_t;

  typedef struct packed {
    logic latchVictim;
    logic capture;
    logic install;
    logic access;
    logic selWb;
  } tlbCtrl_t;
endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlbPkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbCtrl_t          ctrl,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] ptBase,
  input  logic              clearRef,
  input  logic              invalAll,
  input  logic [ADDR_W-1:0] memRdata,
  output logic              hit,
  output logic [ADDR_W-1:0] respPaddr,
  output logic              victimDirty,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int VPN_W = ADDR_W - OFF_W;
  localparam int PAD_W = OFF_W - 3;

  logic [ENTRIES-1:0] validQ, refQ, dirtyQ, match;
  logic [VPN_W-1:0]   vpnQ [ENTRIES];
  logic [VPN_W-1:0]   ppnQ [ENTRIES];
  logic [VPN_W-1:0]   reqVpn, missVpnQ, addrVpn;
  logic [IDX_W-1:0]   hitIdx, freeIdx, victimQ, rrQ;
  logic               anyFree, usedRrQ;
  logic [ADDR_W-1:0]  fetchedQ;

  assign reqVpn = reqVaddr[ADDR_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : gCompare
    assign match[g] = validQ[g] && (vpnQ[g] == reqVpn);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) hitIdx = IDX_W'(i);
  end

  always_comb begin
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!validQ[i]) freeIdx = IDX_W'(i);
  end

  assign anyFree     = ~&validQ;
  assign hit         = |match;
  assign respPaddr   = {ppnQ[hitIdx], reqVaddr[OFF_W-1:0]};
  assign victimDirty = validQ[victimQ] && dirtyQ[victimQ];
  assign addrVpn     = ctrl.selWb ? vpnQ[victimQ] : missVpnQ;
  assign memAddr     = ptBase + (ADDR_W'(addrVpn) << 2);
  assign memWdata    = {ppnQ[victimQ], PAD_W'(0), dirtyQ[victimQ], refQ[victimQ], 1'b1};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ   <= '0;
      refQ     <= '0;
      dirtyQ   <= '0;
      victimQ  <= '0;
      rrQ      <= '0;
      usedRrQ  <= 1'b0;
      missVpnQ <= '0;
      fetchedQ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpnQ[i] <= '0;
        ppnQ[i] <= '0;
      end
    end else begin
      if (ctrl.latchVictim) begin
        victimQ  <= anyFree ? freeIdx : rrQ;
        usedRrQ  <= !anyFree;
        missVpnQ <= reqVpn;
      end
      if (ctrl.capture) fetchedQ <= memRdata;
      if (clearRef) refQ <= '0;
      if (ctrl.access) begin
        refQ[hitIdx] <= 1'b1;
        if (reqWrite) dirtyQ[hitIdx] <= 1'b1;
      end
      if (ctrl.install) begin
        validQ[victimQ] <= 1'b1;
        vpnQ[victimQ]   <= missVpnQ;
        ppnQ[victimQ]   <= fetchedQ[ADDR_W-1:OFF_W];
        refQ[victimQ]   <= 1'b0;
        dirtyQ[victimQ] <= 1'b0;
        if (usedRrQ) rrQ <= (rrQ == IDX_W'(ENTRIES - 1)) ? '0 : rrQ + 1'b1;
      end
      if (invalAll) validQ <= '0;
    end
  end

  // R2: a virtual page is never cached twice
  assert_single_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(match));
  // R6: a store hit leaves the entry modified
  assert_store_dirty_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.access && reqWrite |=> dirtyQ[$past(hitIdx)]);
  // R10: flush empties the array
  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rstN)
    invalAll |=> validQ == '0);
  // R4: install makes the walked page resident in the chosen slot
  assert_install_lands_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.install && !invalAll |=> validQ[$past(victimQ)] && vpnQ[$past(victimQ)] == $past(missVpnQ));
endmodule

// File: rtl/tlb_control.sv
module tlb_control
  import tlbPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     hit,
  input  logic     memDone,
  input  logic     pteOk,
  input  logic     victimDirty,
  output tlbCtrl_t ctrl,
  output logic     reqReady,
  output logic     respFault,
  output logic     memValid,
  output logic     memWe
);
  walkState_t stateQ, stateD;

  always_comb begin
    stateD    = stateQ;
    ctrl      = '0;
    reqReady  = 1'b0;
    respFault = 1'b0;
    memValid  = 1'b0;
    memWe     = 1'b0;
    case (stateQ)
      ST_IDLE: if (reqValid) begin
        if (hit) begin
          reqReady    = 1'b1;
          ctrl.access = 1'b1;
        end else begin
          ctrl.latchVictim = 1'b1;
          stateD           = ST_FETCH;
        end
      end
      ST_FETCH: begin
        memValid = 1'b1;
        if (memDone) begin
          ctrl.capture = 1'b1;
          stateD = !pteOk ? ST_FAULT : (victimDirty ? ST_WBACK : ST_FILL);
        end
      end
      ST_WBACK: begin
        memValid   = 1'b1;
        memWe      = 1'b1;
        ctrl.selWb = 1'b1;
        if (memDone) stateD = ST_FILL;
      end
      ST_FILL: begin
        ctrl.install = 1'b1;
        stateD       = ST_IDLE;
      end
      ST_FAULT: begin
        reqReady  = 1'b1;
        respFault = 1'b1;
        if (reqValid) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // R11: a pending memory request is held until completion
  assert_mem_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memDone |=> memValid);
  // R5: a fault is only answered after a completed table read
  assert_fault_after_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(respFault) |-> $past(memDone) && $past(memValid) && !$past(memWe));
endmodule

// File: rtl/tlb_walker_top.sv
module tlb_walker_top
  import tlbPkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  output logic              reqReady,
  output logic [ADDR_W-1:0] respPaddr,
  output logic              respFault,
  input  logic [ADDR_W-1:0] ptBase,
  input  logic              clearRef,
  input  logic              invalAll,
  output logic              memValid,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  input  logic              memDone,
  input  logic [ADDR_W-1:0] memRdata
);
  tlbCtrl_t ctrl;
  logic     hit, victimDirty;

  tlb_control uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .hit(hit), .memDone(memDone),
    .pteOk(memRdata[0]), .victimDirty(victimDirty), .ctrl(ctrl),
    .reqReady(reqReady), .respFault(respFault), .memValid(memValid), .memWe(memWe)
  );

  tlb_datapath #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .ptBase(ptBase), .clearRef(clearRef), .invalAll(invalAll), .memRdata(memRdata),
    .hit(hit), .respPaddr(respPaddr), .victimDirty(victimDirty),
    .memAddr(memAddr), .memWdata(memWdata)
  );

  // R5: a faulting answer never coincides with memory traffic or an install
  assert_fault_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    respFault |-> !memValid && !ctrl.install);
  // R11: address of a pending request does not move
  assert_addr_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memDone |=> $stable(memAddr));
endmodule

// File: tb/tb_tlb_walker_top.sv
module tb_tlb_walker_top;
  logic        clk = 0, rstN = 0;
  logic        reqValid = 0, reqWrite = 0, clearRef = 0, invalAll = 0;
  logic [31:0] reqVaddr = '0;
  logic [31:0] ptBase = 32'h0010_0000;
  logic        reqReady, respFault, memValid, memWe;
  logic [31:0] respPaddr, memAddr, memWdata;
  logic        memDone = 0;
  logic [31:0] memRdata = '0;

  int errors = 0, checks = 0;
  int rdCount = 0, wrCount = 0, memCnt = 0;
  logic [31:0] lastRdAddr = '0, lastWrAddr = '0, lastWrData = '0, startAddr = '0;
  bit finished = 0;

  always #10 clk = ~clk;

  tlb_walker_top dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .reqReady(reqReady), .respPaddr(respPaddr), .respFault(respFault), .ptBase(ptBase),
    .clearRef(clearRef), .invalAll(invalAll), .memValid(memValid), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memDone(memDone), .memRdata(memRdata)
  );

  function automatic logic [19:0] ppnOf(input logic [19:0] vpn);
    return vpn + 20'h30000;
  endfunction

  function automatic logic [31:0] pteOf(input logic [19:0] vpn);
    return {ppnOf(vpn), 11'b0, (vpn[7:0] != 8'hFF)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: answers on the third falling edge with memValid high
  always @(negedge clk) begin
    memDone = 0;
    if (memValid) begin
      if (memCnt == 0) startAddr = memAddr;
      memCnt++;
      if (memCnt == 3) begin
        check(memAddr == startAddr, "R11", "address held while pending", memAddr, startAddr);
        if (memWe) begin
          wrCount++; lastWrAddr = memAddr; lastWrData = memWdata;
        end else begin
          rdCount++; lastRdAddr = memAddr;
          memRdata = pteOf(20'((memAddr - ptBase) >> 2));
        end
        memDone = 1;
        memCnt = 0;
      end
    end else memCnt = 0;
  end

  task automatic access(input logic [31:0] va, input bit wr,
                        output logic [31:0] pa, output bit flt, output int waits);
    waits = 0;
    @(negedge clk);
    reqValid = 1; reqVaddr = va; reqWrite = wr;
    #1;
    while (!reqReady) begin
      @(negedge clk); #1; waits++;
    end
    pa = respPaddr; flt = respFault;
    @(posedge clk); #1;
    reqValid = 0; reqWrite = 0;
  endtask

  task automatic pulseInval();
    @(negedge clk); invalAll = 1; @(negedge clk); invalAll = 0;
  endtask

  task automatic pulseClearRef();
    @(negedge clk); clearRef = 1; @(negedge clk); clearRef = 0;
  endtask

  task automatic testReset();
    @(negedge clk); #1;
    check(reqReady == 0, "R1", "reset reqReady", reqReady, 0);
    check(memValid == 0, "R11", "reset memValid", memValid, 0);
    check(respFault == 0, "R5", "reset respFault", respFault, 0);
  endtask

  task automatic testMissThenHit();
    logic [31:0] pa; bit flt; int w, rd0;
    rd0 = rdCount;
    access(32'h0001_2345, 0, pa, flt, w);
    check(w > 0, "R3", "miss waits", w, 1);
    check(lastRdAddr == ptBase + 32'h48, "R3", "walk address", lastRdAddr, ptBase + 32'h48);
    check(pa == {ppnOf(20'h12), 12'h345}, "R4", "paddr after refill", pa, {ppnOf(20'h12), 12'h345});
    check(flt == 0, "R4", "no fault", flt, 0);
    rd0 = rdCount;
    access(32'h0001_2ABC, 0, pa, flt, w);
    check(w == 0, "R1", "hit same cycle", w, 0);
    check(pa == {ppnOf(20'h12), 12'hABC}, "R1", "hit paddr", pa, {ppnOf(20'h12), 12'hABC});
    check(rdCount == rd0, "R1", "hit no memory", rdCount, rd0);
  endtask

  task automatic testFault();
    logic [31:0] pa; bit flt; int w, rd0, wr0;
    rd0 = rdCount; wr0 = wrCount;
    access(32'h000F_F010, 1, pa, flt, w);
    check(flt == 1, "R5", "fault flagged", flt, 1);
    check(wrCount == wr0, "R5", "no write on fault", wrCount, wr0);
    access(32'h000F_F010, 0, pa, flt, w);
    check(flt == 1 && rdCount == rd0 + 2, "R5", "fault not installed", rdCount, rd0 + 2);
    access(32'h0001_2000, 0, pa, flt, w);
    check(w == 0 && flt == 0, "R2", "earlier entry still hits", w, 0);
  endtask

  task automatic testReplacement();
    logic [31:0] pa; bit flt; int w, wr0;
    pulseInval();
    for (int i = 0; i < 16; i++) access({20'h100 + 20'(i), 12'h0}, 0, pa, flt, w);
    access({20'h100, 12'h0}, 1, pa, flt, w);
    check(w == 0, "R2", "16 entries resident", w, 0);
    pulseClearRef();
    wr0 = wrCount;
    access({20'h110, 12'h0}, 0, pa, flt, w);
    check(wrCount == wr0 + 1, "R9", "dirty victim written", wrCount, wr0 + 1);
    check(lastWrAddr == ptBase + 32'h400, "R8", "slot 0 victim first", lastWrAddr, ptBase + 32'h400);
    check(lastWrData == {ppnOf(20'h100), 12'b101}, "R7", "writeback ref cleared", lastWrData,
          {ppnOf(20'h100), 12'b101});
    check(pa == {ppnOf(20'h110), 12'h0}, "R9", "install after writeback", pa, {ppnOf(20'h110), 12'h0});
    wr0 = wrCount;
    access({20'h111, 12'h0}, 0, pa, flt, w);
    check(wrCount == wr0, "R9", "clean victim not written", wrCount, wr0);
    access({20'h101, 12'h0}, 0, pa, flt, w);
    check(w > 0, "R8", "rotation evicted slot 1", w, 1);
    access({20'h103, 12'h0}, 1, pa, flt, w);
    check(w == 0, "R8", "slot 3 untouched so far", w, 0);
    wr0 = wrCount;
    access({20'h112, 12'h0}, 0, pa, flt, w);
    check(wrCount == wr0 + 1 && lastWrData == {ppnOf(20'h103), 12'b111}, "R6",
          "store hit sets ref and dirty", lastWrData, {ppnOf(20'h103), 12'b111});
  endtask

  task automatic testFlush();
    logic [31:0] pa; bit flt; int w, wr0;
    access({20'h110, 12'h0}, 1, pa, flt, w);
    check(w == 0, "R10", "page resident before flush", w, 0);
    pulseInval();
    wr0 = wrCount;
    access({20'h110, 12'h0}, 0, pa, flt, w);
    check(w > 0, "R10", "miss after flush", w, 1);
    check(wrCount == wr0, "R10", "flush drops dirty without write", wrCount, wr0);
    access({20'h111, 12'h0}, 0, pa, flt, w);
    check(w > 0 && wrCount == wr0, "R8", "empty slot used before rotation", wrCount, wr0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    testReset();
    testMissThenHit();
    testFault();
    testReplacement();
    testFlush();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule